// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small integer core that splits every instruction into five steps (fetch, decode, execute, memory access and write-back) and keeps one instruction in each step. Four register banks sit between the steps, and all of them advance on every clock edge. The core runs four operations: register add, register nand, load word and store word. It has eight 32-bit registers. Instruction storage and data storage are word arrays inside the block.

Programs are placed into both arrays through a preload port while reset is held. After reset is released the core fetches one instruction per cycle from address 0 upward. Its state is read back through two debug ports, one on the register file and one on the data array, together with the program counter. The core does no hazard detection, forwarding or stalling. A program must therefore place each consumer of a register at least three instruction slots after the instruction that writes it.

Top module: `pipe5_core`

## Requirements
- R1: While reset (rst_n low, sampled on the clock edge) is applied, the program counter becomes 0, all eight registers become 0 and every pipeline stage holds a no-op. No register is written during the first four cycles after reset is released.
- R2: The program counter rises by 4 on every clock edge while reset is released. The instruction in each cycle is read from instruction word pc[7:2], and the address wraps after 64 words.
- R3: Opcode 0110011 (bits 6:0) with funct3 000 (bits 14:12) writes rs1 + rs2 (modulo 2^32) to rd. The register fields are rd = bits 11:7, rs1 = bits 19:15 and rs2 = bits 24:20, and only the low 3 bits of each field select a register.
- R4: Opcode 0110011 with funct3 111 writes ~(rs1 & rs2) to rd.
- R5: Opcode 0000011 loads data word ((rs1 + sext(bits 31:20)) >> 2) mod 64 into rd.
- R6: Opcode 0100011 stores rs2 into data word ((rs1 + sext({bits 31:25, bits 11:7})) >> 2) mod 64. A load that follows a store in the next slot sees the stored value.
- R7: A register write from the instruction at word k becomes visible on the debug port at the edge that makes pc equal 4(k+5), and not one edge earlier.
- R8: An instruction three slots after the instruction that writes its source register reads the new value. The register file passes a same-cycle write through to the decode read.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: Any other opcode, and opcode 0110011 with a funct3 other than 000 or 111, changes no register and no data word.
- R11: With load_we high at a clock edge, load_data is written to instruction word load_addr when load_dmem is 0, or to data word load_addr when load_dmem is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Preload write strobe |
| load_dmem | input | 1 | Preload target: 0 instruction array, 1 data array |
| load_addr | input | 6 | Preload word index |
| load_data | input | 32 | Preload word |
| pc_out | output | 32 | Current fetch address |
| dbg_reg_idx | input | 3 | Debug register select |
| dbg_reg_data | output | 32 | Selected register value |
| dbg_mem_idx | input | 6 | Debug data word select |
| dbg_mem_data | output | 32 | Selected data word |

## Verification
The hardest case to reach from the ports is the producer/consumer pair exactly three slots apart. Here the consumer decodes in the same cycle that the producer writes back, so only the register-file pass-through delivers the correct operand. A directed program places two loads followed by an add at that distance, and it samples the destination on the edges just before and just at its write-back to pin down the five-stage latency. Random programs then draw their source registers only from registers not written in the two preceding slots. They mix address wrap, register-field upper bits, x0 destinations and undecodable words. Their final register and data contents are compared with a sequential interpreter in the bench.

// File: rtl/pipe5_pkg.sv
// Shared encodings and control bundle for the five-stage pipeline.
// Assumes 32-bit instructions with the opcode in bits 6:0.
package pipe5_pkg;

    localparam int XLEN = 32;

    localparam logic [6:0] OP_REG   = 7'b0110011;
    localparam logic [6:0] OP_LOAD  = 7'b0000011;
    localparam logic [6:0] OP_STORE = 7'b0100011;

    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_NAND = 3'b111;

    typedef enum logic [0:0] {
        ALU_ADD  = 1'b0,
        ALU_NAND = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    mem_rd;
        logic    mem_wr;
        logic    use_imm;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '0;

endpackage

// File: rtl/pipe5_regfile.sv
// Register file: NUM_REGS words, two decode read ports and one debug read port.
// Register 0 is held at zero. A write in the same cycle as a read of the same
// register is passed straight to the read port. Synchronous active-low reset
// clears every register.
module pipe5_regfile #(
    parameter int NUM_REGS = 8,
    parameter int XLEN     = 32,
    localparam int RAW     = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  raddr_a,
    output logic [XLEN-1:0] rdata_a,
    input  logic [RAW-1:0]  raddr_b,
    output logic [XLEN-1:0] rdata_b,
    input  logic [RAW-1:0]  dbg_addr,
    output logic [XLEN-1:0] dbg_data
);

    logic [XLEN-1:0] regs [NUM_REGS];
    logic [RAW-1:0]  rsel [2];
    logic [XLEN-1:0] rval [2];

    // Storage update: clear on reset, otherwise write any register except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rsel[0] = raddr_a;
    assign rsel[1] = raddr_b;

    // One read path per decode port: zero register, write pass-through, or storage.
    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            if (rsel[p] == '0) begin
                rval[p] = '0;
            end else if (we && waddr == rsel[p]) begin
                rval[p] = wdata;
            end else begin
                rval[p] = regs[rsel[p]];
            end
        end
    end

    assign rdata_a  = rval[0];
    assign rdata_b  = rval[1];
    assign dbg_data = regs[dbg_addr];

    // Register 0 never returns a non-zero value to decode.
    assert_x0_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_b == '0) |-> (rdata_b == '0));

    // A write landing in the same cycle reaches the decode read.
    assert_write_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0 && waddr == raddr_a) |-> (rdata_a == wdata));

endmodule

// File: rtl/pipe5_decode.sv
// Instruction decoder: turns one instruction word into the control bundle,
// register indices and sign-extended immediate. Assumes only the low bits of
// each 5-bit register field select a register. Unknown words decode as a no-op.
module pipe5_decode
    import pipe5_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int RAW     = $clog2(NUM_REGS)
) (
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl,
    output logic [RAW-1:0]  rd,
    output logic [RAW-1:0]  rs1,
    output logic [RAW-1:0]  rs2,
    output logic [XLEN-1:0] imm
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic       unused_rs1_hi;

    assign opcode = instr[6:0];
    assign funct3 = instr[14:12];
    assign rd     = instr[7 +: RAW];
    assign rs1    = instr[15 +: RAW];
    assign rs2    = instr[20 +: RAW];
    assign unused_rs1_hi = ^instr[19:15+RAW];

    // Control and immediate selection by opcode and function field.
    always_comb begin
        ctrl = CTRL_NOP;
        imm  = '0;
        unique case (opcode)
            OP_REG: begin
                if (funct3 == F3_ADD) begin
                    ctrl.reg_we = 1'b1;
                    ctrl.alu_op = ALU_ADD;
                end else if (funct3 == F3_NAND) begin
                    ctrl.reg_we = 1'b1;
                    ctrl.alu_op = ALU_NAND;
                end
            end
            OP_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.use_imm = 1'b1;
                imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
            end
            OP_STORE: begin
                ctrl.mem_wr  = 1'b1;
                ctrl.use_imm = 1'b1;
                imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pipe5_alu.sv
// Execute-stage arithmetic: add or nand of two operands. Purely combinational.
module pipe5_alu
    import pipe5_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    // Operation select.
    always_comb begin
        unique case (op)
            ALU_NAND: y = ~(a & b);
            default:  y = a + b;
        endcase
    end

endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order pipeline: fetch, decode, execute, memory, write-back.
// Four register banks advance together every cycle. No hazard logic: the
// program must keep a consumer three or more slots behind its producer.
// Instruction and data arrays are preloaded through the load port, normally
// while reset is held. Synchronous active-low reset.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NUM_REGS   = 8,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int RAW = $clog2(NUM_REGS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_we,
    input  logic            load_dmem,
    input  logic [LAW-1:0]  load_addr,
    input  logic [XLEN-1:0] load_data,
    output logic [XLEN-1:0] pc_out,
    input  logic [RAW-1:0]  dbg_reg_idx,
    output logic [XLEN-1:0] dbg_reg_data,
    input  logic [DAW-1:0]  dbg_mem_idx,
    output logic [XLEN-1:0] dbg_mem_data
);

    localparam int QUIET_CYCLES = 4;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    // Fetch and IF/ID
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] fetch_instr;
    logic [XLEN-1:0] ifid_instr;

    // Decode outputs and ID/EX
    ctrl_t           dec_ctrl;
    logic [RAW-1:0]  dec_rd, dec_rs1, dec_rs2;
    logic [XLEN-1:0] dec_imm, rf_a, rf_b;
    ctrl_t           idex_ctrl;
    logic [RAW-1:0]  idex_rd;
    logic [XLEN-1:0] idex_imm, idex_a, idex_b;

    // Execute and EX/MEM
    logic [XLEN-1:0] alu_b, alu_y;
    ctrl_t           exmem_ctrl;
    logic [RAW-1:0]  exmem_rd;
    logic [XLEN-1:0] exmem_alu, exmem_b;

    // Memory and MEM/WB
    logic [DAW-1:0]  mem_idx;
    logic [XLEN-1:0] mem_rdata;
    ctrl_t           memwb_ctrl;
    logic [RAW-1:0]  memwb_rd;
    logic [XLEN-1:0] memwb_mdata, memwb_alu;

    // Write-back
    logic            wb_we;
    logic [XLEN-1:0] wb_data;

    logic [2:0]      quiet_cnt;
    logic            unused_bits;

    // Instruction array preload.
    always_ff @(posedge clk) begin
        if (load_we && !load_dmem) begin
            imem[load_addr[IAW-1:0]] <= load_data;
        end
    end

    // Program counter: cleared on reset, then steps one word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            pc <= pc + XLEN'(4);
        end
    end

    assign fetch_instr = imem[pc[IAW+1:2]];
    assign pc_out      = pc;

    // IF/ID bank: a zero word decodes as a no-op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifid_instr <= '0;
        end else begin
            ifid_instr <= fetch_instr;
        end
    end

    pipe5_decode #(.NUM_REGS(NUM_REGS)) i_decode (
        .instr (ifid_instr),
        .ctrl  (dec_ctrl),
        .rd    (dec_rd),
        .rs1   (dec_rs1),
        .rs2   (dec_rs2),
        .imm   (dec_imm)
    );

    pipe5_regfile #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) i_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wb_we),
        .waddr    (memwb_rd),
        .wdata    (wb_data),
        .raddr_a  (dec_rs1),
        .rdata_a  (rf_a),
        .raddr_b  (dec_rs2),
        .rdata_b  (rf_b),
        .dbg_addr (dbg_reg_idx),
        .dbg_data (dbg_reg_data)
    );

    // ID/EX bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_ctrl <= CTRL_NOP;
            idex_rd   <= '0;
            idex_imm  <= '0;
            idex_a    <= '0;
            idex_b    <= '0;
        end else begin
            idex_ctrl <= dec_ctrl;
            idex_rd   <= dec_rd;
            idex_imm  <= dec_imm;
            idex_a    <= rf_a;
            idex_b    <= rf_b;
        end
    end

    assign alu_b = idex_ctrl.use_imm ? idex_imm : idex_b;

    pipe5_alu i_alu (
        .op (idex_ctrl.alu_op),
        .a  (idex_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    // EX/MEM bank: the second register value travels on as store data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exmem_ctrl <= CTRL_NOP;
            exmem_rd   <= '0;
            exmem_alu  <= '0;
            exmem_b    <= '0;
        end else begin
            exmem_ctrl <= idex_ctrl;
            exmem_rd   <= idex_rd;
            exmem_alu  <= alu_y;
            exmem_b    <= idex_b;
        end
    end

    assign mem_idx      = exmem_alu[DAW+1:2];
    assign mem_rdata    = dmem[mem_idx];
    assign dbg_mem_data = dmem[dbg_mem_idx];

    // Data array: preload has priority over a pipeline store.
    always_ff @(posedge clk) begin
        if (load_we && load_dmem) begin
            dmem[load_addr[DAW-1:0]] <= load_data;
        end else if (exmem_ctrl.mem_wr) begin
            dmem[mem_idx] <= exmem_b;
        end
    end

    // MEM/WB bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            memwb_ctrl  <= CTRL_NOP;
            memwb_rd    <= '0;
            memwb_mdata <= '0;
            memwb_alu   <= '0;
        end else begin
            memwb_ctrl  <= exmem_ctrl;
            memwb_rd    <= exmem_rd;
            memwb_mdata <= mem_rdata;
            memwb_alu   <= exmem_alu;
        end
    end

    assign wb_we   = memwb_ctrl.reg_we;
    assign wb_data = memwb_ctrl.mem_rd ? memwb_mdata : memwb_alu;

    assign unused_bits = ^{pc[XLEN-1:IAW+2], pc[1:0],
                           exmem_alu[XLEN-1:DAW+2], exmem_alu[1:0],
                           exmem_ctrl.use_imm, exmem_ctrl.alu_op,
                           memwb_ctrl.mem_wr, memwb_ctrl.use_imm, memwb_ctrl.alu_op};

    // Cycles since reset release, saturating, for the start-up check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt < 3'(QUIET_CYCLES)) begin
            quiet_cnt <= quiet_cnt + 3'd1;
        end
    end

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pc == $past(pc) + XLEN'(4)));

    assert_startup_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt < 3'(QUIET_CYCLES)) |-> !wb_we);

endmodule

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_we = 1'b0;
    logic        load_dmem = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_out;
    logic [2:0]  dbg_reg_idx = '0;
    logic [31:0] dbg_reg_data;
    logic [5:0]  dbg_mem_idx = '0;
    logic [31:0] dbg_mem_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] prog  [64];
    logic [31:0] dinit [64];
    logic [31:0] m_reg [8];
    logic [31:0] m_mem [64];

    always #10 clk = ~clk;

    pipe5_core i_pipe5_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_we      (load_we),
        .load_dmem    (load_dmem),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .pc_out       (pc_out),
        .dbg_reg_idx  (dbg_reg_idx),
        .dbg_reg_data (dbg_reg_data),
        .dbg_mem_idx  (dbg_mem_idx),
        .dbg_mem_data (dbg_mem_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [4:0] rs1, input logic [4:0] rs2);
        return {7'b0, rs2, rs1, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_lw(input logic [4:0] rd, input logic [4:0] rs1,
                                           input logic [11:0] imm);
        return {imm, rs1, 3'b010, rd, 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_sw(input logic [4:0] rs2, input logic [4:0] rs1,
                                           input logic [11:0] imm);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
    endfunction

    // Sequential interpreter written from the requirement text.
    function automatic void model_exec(input logic [31:0] ins);
        logic [2:0]  rd  = ins[9:7];
        logic [2:0]  rs1 = ins[17:15];
        logic [2:0]  rs2 = ins[22:20];
        logic [31:0] a   = m_reg[rs1];
        logic [31:0] b   = m_reg[rs2];
        logic [31:0] ea;
        logic [31:0] res = '0;
        bit          wr  = 1'b0;
        case (ins[6:0])
            7'b0110011: begin
                if (ins[14:12] == 3'b000) begin res = a + b; wr = 1'b1; end
                else if (ins[14:12] == 3'b111) begin res = ~(a & b); wr = 1'b1; end
            end
            7'b0000011: begin
                ea  = a + {{20{ins[31]}}, ins[31:20]};
                res = m_mem[ea[7:2]];
                wr  = 1'b1;
            end
            7'b0100011: begin
                ea = a + {{20{ins[31]}}, ins[31:25], ins[11:7]};
                m_mem[ea[7:2]] = b;
            end
            default: ;
        endcase
        if (wr && rd != 3'd0) m_reg[rd] = res;
    endfunction

    task automatic preload();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_dmem = 1'b0; load_addr = 6'(i); load_data = prog[i];
        end
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_dmem = 1'b1; load_addr = 6'(i); load_data = dinit[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic get_reg(input int idx, output logic [31:0] v);
        dbg_reg_idx = 3'(idx);
        #1 v = dbg_reg_data;
    endtask

    task automatic get_mem(input int idx, output logic [31:0] v);
        dbg_mem_idx = 6'(idx);
        #1 v = dbg_mem_data;
    endtask

    task automatic compare_all(input string tag);
        logic [31:0] v;
        for (int r = 0; r < 8; r++) begin
            get_reg(r, v);
            check("R3/R4/R5/R9", $sformatf("%s reg x%0d", tag, r), v, m_reg[r]);
        end
        for (int w = 0; w < 64; w++) begin
            get_mem(w, v);
            check("R6/R10", $sformatf("%s data word %0d", tag, w), v, m_mem[w]);
        end
    endtask

    function automatic logic [4:0] pick_src(input logic [2:0] l1, input logic [2:0] l2);
        logic [2:0] r;
        do r = 3'($urandom % 8); while (r != 3'd0 && (r == l1 || r == l2));
        return {2'($urandom % 4), r};
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] va, vb;
        logic [2:0]  last1, last2;
        void'($urandom(32'd20240611));

        // ---------------- Directed program ----------------
        va = 32'h1234_5678;
        vb = 32'h0F0F_F0F0;
        for (int i = 0; i < 64; i++) begin
            prog[i]  = '0;
            dinit[i] = 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101);
        end
        dinit[0] = va;
        dinit[1] = vb;
        prog[0]  = enc_lw(5'd1, 5'd0, 12'd0);
        prog[1]  = enc_lw(5'd2, 5'd0, 12'd4);
        prog[2]  = enc_r(3'b010, 5'd5, 5'd1, 5'd2);           // unsupported funct3
        prog[3]  = {20'hFFFFF, 5'd7, 7'b0010011};             // unknown opcode
        prog[4]  = enc_r(3'b000, 5'd3, 5'd1, 5'd2);           // three slots after x2
        prog[5]  = enc_r(3'b111, 5'd4, 5'd1, 5'd2);
        prog[6]  = enc_r(3'b000, 5'd0, 5'd1, 5'd2);           // x0 destination
        prog[7]  = enc_sw(5'd3, 5'd0, 12'd8);
        prog[8]  = enc_lw(5'd6, 5'd0, 12'd8);                 // load right after store
        prog[9]  = {25'h1FFFFFF, 7'b1111111};
        prog[10] = enc_r(3'b000, 5'd13, 5'd9, 5'd10);         // upper field bits
        prog[11] = enc_sw(5'd4, 5'd0, 12'hFFC);               // wraps to word 63
        prog[12] = enc_lw(5'd7, 5'd0, 12'hFFC);

        for (int r = 0; r < 8; r++) m_reg[r] = '0;
        for (int w = 0; w < 64; w++) m_mem[w] = dinit[w];
        for (int i = 0; i < 13; i++) model_exec(prog[i]);

        preload();
        check("R1", "pc in reset", pc_out, 32'd0);
        for (int r = 0; r < 8; r++) begin
            get_reg(r, v);
            check("R1", $sformatf("reg x%0d in reset", r), v, 32'd0);
        end
        get_mem(1, v);
        check("R11", "preloaded data word 1", v, vb);

        @(negedge clk);
        rst_n = 1'b1;
        run_edges(4);
        check("R2", "pc after 4 edges", pc_out, 32'd16);
        get_reg(1, v);
        check("R1", "x1 untouched in first four cycles", v, 32'd0);
        run_edges(1);
        check("R2", "pc after 5 edges", pc_out, 32'd20);
        get_reg(1, v);
        check("R7", "x1 loaded at edge five", v, va);
        run_edges(3);
        get_reg(5, v);
        check("R10", "x5 after bad funct3", v, 32'd0);
        get_reg(7, v);
        check("R10", "x7 after unknown opcode", v, 32'd0);
        get_reg(3, v);
        check("R7", "x3 one edge before write", v, 32'd0);
        run_edges(1);
        get_reg(3, v);
        check("R8", "x3 with operand three slots back", v, va + vb);
        run_edges(31);
        check("R2", "pc after 40 edges", pc_out, 32'd160);
        get_reg(0, v);
        check("R9", "x0 after write attempt", v, 32'd0);
        get_reg(4, v);
        check("R4", "x4 nand", v, ~(va & vb));
        get_reg(6, v);
        check("R6", "load after store", v, va + vb);
        get_mem(63, v);
        check("R6", "store wrapped to word 63", v, ~(va & vb));
        compare_all("directed");

        // ---------------- Random programs ----------------
        for (int round = 0; round < 4; round++) begin
            last1 = 3'd0;
            last2 = 3'd0;
            for (int i = 0; i < 56; i++) begin
                int kind = int'($urandom % 6);
                logic [4:0]  s1 = pick_src(last1, last2);
                logic [4:0]  s2 = pick_src(last1, last2);
                logic [4:0]  d  = 5'($urandom % 32);
                logic [11:0] im = 12'($urandom);
                logic [2:0]  nd = 3'd0;
                case (kind)
                    0: begin prog[i] = enc_r(3'b000, d, s1, s2); nd = d[2:0]; end
                    1: begin prog[i] = enc_r(3'b111, d, s1, s2); nd = d[2:0]; end
                    2: begin prog[i] = enc_lw(d, s1, im); nd = d[2:0]; end
                    3: prog[i] = enc_sw(s2, s1, im);
                    4: prog[i] = enc_r(3'($urandom % 6) + 3'd1, d, s1, s2);
                    default: prog[i] = {25'($urandom), 7'b1011011};
                endcase
                last2 = last1;
                last1 = nd;
            end
            for (int i = 56; i < 64; i++) prog[i] = '0;
            for (int w = 0; w < 64; w++) dinit[w] = $urandom;

            for (int r = 0; r < 8; r++) m_reg[r] = '0;
            for (int w = 0; w < 64; w++) m_mem[w] = dinit[w];
            for (int i = 0; i < 56; i++) model_exec(prog[i]);

            preload();
            @(negedge clk);
            rst_n = 1'b1;
            run_edges(62);
            check("R2", $sformatf("round %0d pc", round), pc_out, 32'd248);
            compare_all($sformatf("random round %0d", round));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule